// File: doc/BRIEF.md
# Maximum-Weight Basis Soft Decoder

This block decodes one short block of a systematic rate-1/2 convolutional code with memory 2. It does not run a trellis search. It takes sixteen signed soft values, one for each coded symbol, and ranks the coded positions by reliability. It then walks that ranking, keeping each position whose code constraint over the eight data bits is linearly independent over GF(2) of the positions already kept. When eight positions are kept, it fixes them to their hard decisions, solves for the data bits and re-encodes the result. It scores the codeword by correlating it with the soft inputs.

Four candidate selections are built this way, and the data word with the best score is presented with a one-cycle done pulse. Soft values arrive one per cycle over a valid/ready handshake, in coded-position order. The block accepts no new input until the current block has been decoded.

Top module: `mwb_decoder`

## Requirements
- R1: A sample is accepted on a rising edge where in_valid and in_ready are both high. Sixteen samples form a block, taken in position order 0..15. in_ready is high only while a block is being collected, and it is high again in the cycle that done_o is high. in_valid is ignored while in_ready is low.
- R2: Coded position 2i carries data bit i. Position 2i+1 carries the parity d[i] xor d[i-1] xor d[i-2], with data bits before bit 0 taken as 0. A noise-free codeword in bipolar form (+A for bit 0, -A for bit 1) decodes to its own data word.
- R3: Positions are ranked by decreasing magnitude |y|, where |-2048| = 2048. Equal magnitudes are ranked with the lower position index first.
- R4: For each candidate, ranked positions are taken in rank order. A position is kept only if its constraint vector is independent of those already kept, and selection stops at eight kept positions.
- R5: The hard decision of a position is 1 when its soft value is negative. It is 0 when the value is zero or positive. The decoded data word is the unique word whose codeword matches the hard decisions at all eight kept positions.
- R6: The score of a candidate is the sum over all sixteen positions of +y for a code bit 0 and -y for a code bit 1. The output is the candidate with the largest score, and on equal scores the lower-numbered candidate wins.
- R7: Candidate 0 uses the full ranking. Candidate j, for j = 1..3, removes the position of rank j-1 (0-based, so rank 0 is the most reliable) from consideration.
- R8: done_o is high for exactly one cycle, 69 clock cycles after the edge that accepts a block's last sample. data_o changes only together with done_o and holds its value between pulses.
- R9: After reset, in_ready is 1, done_o is 0 and data_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Soft sample present on in_soft |
| in_ready | output | 1 | Block collection in progress, sample can be taken |
| in_soft | input | 12 | Two's-complement soft value of the current coded position |
| done_o | output | 1 | One-cycle pulse marking a new decoded word |
| data_o | output | 8 | Decoded data word, bit i is data bit i |

## Verification
The only timed result is the decoded word. It is due exactly 69 clock cycles after the edge that accepts a block's sixteenth sample: one edge for ranking, then sixteen selection edges and one scoring edge for each of the four candidates. When the driver presents the last sample, it records the edge number of the accepting edge plus 69 and queues this with the expected word. The monitor samples at falling edges. It compares the word and the edge number whenever done_o is high, and one cycle later it confirms that the pulse has dropped and the word is held. in_ready is sampled at the falling edge after the last acceptance to confirm that the block has stopped collecting.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_SORT  = 2'd1,
        ST_ELIM  = 2'd2,
        ST_SCORE = 2'd3
    } mwb_state_e;

endpackage

// File: rtl/mwb_rank.sv
module mwb_rank #(
    parameter int NPOS   = 16,
    parameter int SOFT_W = 12,
    localparam int IW    = $clog2(NPOS)
) (
    input  logic [NPOS-1:0][SOFT_W-1:0] soft_i,
    output logic [NPOS-1:0][IW-1:0]     order_o
);

    logic [SOFT_W-1:0] mag [NPOS];

    // magnitude of a two's-complement value, unsigned so the most negative fits
    always_comb begin
        for (int p = 0; p < NPOS; p++) begin
            mag[p] = soft_i[p][SOFT_W-1] ? (~soft_i[p] + SOFT_W'(1)) : soft_i[p];
        end
    end

    // rank of p = number of positions that beat it; earlier index beats on ties
    always_comb begin
        order_o = '0;
        for (int p = 0; p < NPOS; p++) begin
            int rk;
            rk = 0;
            for (int q = 0; q < NPOS; q++) begin
                if (q != p) begin
                    if ((mag[q] > mag[p]) || ((mag[q] == mag[p]) && (q < p))) begin
                        rk = rk + 1;
                    end
                end
            end
            order_o[rk[IW-1:0]] = IW'(p);
        end
    end

endmodule

// File: rtl/mwb_basis.sv
module mwb_basis #(
    parameter int DATA_BITS = 8,
    localparam int NPOS     = 2 * DATA_BITS,
    localparam int IW       = $clog2(NPOS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear_i,
    input  logic                                step_i,
    input  logic [IW-1:0]                       pos_i,
    input  logic                                hard_i,
    output logic [DATA_BITS-1:0][DATA_BITS-1:0] rows_o,
    output logic [DATA_BITS-1:0]                rhs_o,
    output logic [DATA_BITS-1:0]                valid_o
);

    typedef struct packed {
        logic [DATA_BITS-1:0][DATA_BITS-1:0] rows;
        logic [DATA_BITS-1:0]                rhs;
        logic [DATA_BITS-1:0]                valid;
    } basis_t;

    basis_t bs_d, bs_q;

    // constraint vector of a coded position over the data bits
    function automatic logic [DATA_BITS-1:0] coef(input int p);
        logic [DATA_BITS-1:0] v;
        int i;
        v = '0;
        i = p / 2;
        if ((p % 2) == 0) begin
            v[i] = 1'b1;
        end else begin
            v[i] = 1'b1;
            if (i >= 1) v[i-1] = 1'b1;
            if (i >= 2) v[i-2] = 1'b1;
        end
        return v;
    endfunction

    logic [DATA_BITS-1:0] red_v;
    logic                 red_r;
    int                   lead;

    always_comb begin
        // reduce against stored rows, highest pivot first
        red_v = coef(int'(pos_i));
        red_r = hard_i;
        for (int k = DATA_BITS - 1; k >= 0; k--) begin
            if (red_v[k] && bs_q.valid[k]) begin
                red_v = red_v ^ bs_q.rows[k];
                red_r = red_r ^ bs_q.rhs[k];
            end
        end
        lead = 0;
        for (int k = 0; k < DATA_BITS; k++) begin
            if (red_v[k]) lead = k;
        end

        bs_d = bs_q;
        if (clear_i) begin
            bs_d = '0;
        end else if (step_i && (red_v != '0)) begin
            bs_d.rows[lead]  = red_v;
            bs_d.rhs[lead]   = red_r;
            bs_d.valid[lead] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign rows_o  = bs_q.rows;
    assign rhs_o   = bs_q.rhs;
    assign valid_o = bs_q.valid;

endmodule

// File: rtl/mwb_solve.sv
module mwb_solve #(
    parameter int DATA_BITS = 8,
    parameter int SOFT_W    = 12,
    localparam int NPOS     = 2 * DATA_BITS,
    localparam int MW       = SOFT_W + $clog2(NPOS) + 1
) (
    input  logic [DATA_BITS-1:0][DATA_BITS-1:0] rows_i,
    input  logic [DATA_BITS-1:0]                rhs_i,
    input  logic [NPOS-1:0][SOFT_W-1:0]         soft_i,
    output logic [DATA_BITS-1:0]                data_o,
    output logic [MW-1:0]                       score_o
);

    logic [NPOS-1:0] code;

    // back-substitution: row k has its leading one at bit k
    always_comb begin
        data_o = '0;
        for (int k = 0; k < DATA_BITS; k++) begin
            data_o[k] = rhs_i[k] ^ (^(rows_i[k] & data_o));
        end
    end

    // re-encode the solved word
    always_comb begin
        for (int i = 0; i < DATA_BITS; i++) begin
            logic par;
            par = data_o[i];
            if (i >= 1) par = par ^ data_o[i-1];
            if (i >= 2) par = par ^ data_o[i-2];
            code[2*i]   = data_o[i];
            code[2*i+1] = par;
        end
    end

    // correlation with the bipolar codeword
    always_comb begin
        logic signed [MW-1:0] acc;
        logic signed [MW-1:0] ext;
        acc = '0;
        for (int p = 0; p < NPOS; p++) begin
            ext = {{(MW-SOFT_W){soft_i[p][SOFT_W-1]}}, soft_i[p]};
            acc = code[p] ? (acc - ext) : (acc + ext);
        end
        score_o = acc;
    end

endmodule

// File: rtl/mwb_decoder.sv
module mwb_decoder
    import mwb_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int SOFT_W    = 12,
    parameter int CANDS     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [SOFT_W-1:0]    in_soft,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] data_o
);

    localparam int NCODE = 2 * DATA_BITS;
    localparam int IW    = $clog2(NCODE);
    localparam int CW    = (CANDS > 1) ? $clog2(CANDS) : 1;
    localparam int MW    = SOFT_W + IW + 1;

    typedef struct packed {
        mwb_state_e                   st;
        logic [IW-1:0]                cnt;
        logic [CW-1:0]                cand;
        logic [NCODE-1:0][SOFT_W-1:0] y;
        logic [NCODE-1:0][IW-1:0]     order;
        logic [MW-1:0]                best_m;
        logic [DATA_BITS-1:0]         best_d;
        logic [DATA_BITS-1:0]         dout;
        logic                         done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCODE-1:0][IW-1:0]            rank_w;
    logic [DATA_BITS-1:0][DATA_BITS-1:0] rows_w;
    logic [DATA_BITS-1:0]                rhs_w;
    logic [DATA_BITS-1:0]                bvalid_w;
    logic [DATA_BITS-1:0]                sol_w;
    logic [MW-1:0]                       score_m;
    logic                                score_w;
    logic                                skip_w;
    logic                                step_w;
    logic [IW-1:0]                       pos_w;
    logic                                hard_w;
    logic                                better_w;

    mwb_rank #(.NPOS(NCODE), .SOFT_W(SOFT_W)) u_rank (
        .soft_i  (ctl_q.y),
        .order_o (rank_w)
    );

    assign score_w = (ctl_q.st == ST_SCORE);
    assign skip_w  = (ctl_q.cand != '0) && (ctl_q.cnt == (IW'(ctl_q.cand) - IW'(1)));
    assign pos_w   = ctl_q.order[ctl_q.cnt];
    assign hard_w  = ctl_q.y[pos_w][SOFT_W-1];
    assign step_w  = (ctl_q.st == ST_ELIM) && !skip_w && !(&bvalid_w);

    mwb_basis #(.DATA_BITS(DATA_BITS)) u_basis (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (score_w || (ctl_q.st == ST_SORT)),
        .step_i  (step_w),
        .pos_i   (pos_w),
        .hard_i  (hard_w),
        .rows_o  (rows_w),
        .rhs_o   (rhs_w),
        .valid_o (bvalid_w)
    );

    mwb_solve #(.DATA_BITS(DATA_BITS), .SOFT_W(SOFT_W)) u_solve (
        .rows_i  (rows_w),
        .rhs_i   (rhs_w),
        .soft_i  (ctl_q.y),
        .data_o  (sol_w),
        .score_o (score_m)
    );

    assign better_w = (ctl_q.cand == '0) || ($signed(score_m) > $signed(ctl_q.best_m));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_LOAD: begin
                if (in_valid) begin
                    ctl_d.y[ctl_q.cnt] = in_soft;
                    ctl_d.cnt          = ctl_q.cnt + IW'(1);
                    if (ctl_q.cnt == IW'(NCODE - 1)) begin
                        ctl_d.st  = ST_SORT;
                        ctl_d.cnt = '0;
                    end
                end
            end
            ST_SORT: begin
                ctl_d.order = rank_w;
                ctl_d.cand  = '0;
                ctl_d.cnt   = '0;
                ctl_d.st    = ST_ELIM;
            end
            ST_ELIM: begin
                ctl_d.cnt = ctl_q.cnt + IW'(1);
                if (ctl_q.cnt == IW'(NCODE - 1)) begin
                    ctl_d.st = ST_SCORE;
                end
            end
            ST_SCORE: begin
                if (better_w) begin
                    ctl_d.best_m = score_m;
                    ctl_d.best_d = sol_w;
                end
                ctl_d.cnt = '0;
                if (ctl_q.cand == CW'(CANDS - 1)) begin
                    ctl_d.dout = better_w ? sol_w : ctl_q.best_d;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_LOAD;
                end else begin
                    ctl_d.cand = ctl_q.cand + CW'(1);
                    ctl_d.st   = ST_ELIM;
                end
            end
            default: ctl_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_LOAD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready = (ctl_q.st == ST_LOAD);
    assign done_o   = ctl_q.done;
    assign data_o   = ctl_q.dout;

endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          done_o,
    input logic [DW-1:0] data_o,
    input logic          in_score,
    input logic [DW-1:0] basis_valid
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                   // R8

    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> in_ready);                                  // R1

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));                          // R8

    AST_BASIS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        in_score |-> (&basis_valid));                          // R4

endmodule

bind mwb_decoder mwb_checker #(.DW(DATA_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .done_o      (done_o),
    .data_o      (data_o),
    .in_score    (score_w),
    .basis_valid (bvalid_w)
);

// File: tb/sim_mwb_decoder.sv
module sim_mwb_decoder;

    localparam int LAT = 69;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_soft = '0;
    logic               in_ready;
    logic               done_o;
    logic [7:0]         data_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit over  = 0;

    logic [7:0] exp_q [$];
    int         due_q [$];
    string      tag_q [$];

    bit [31:0] lf = 32'h1ACE_5EED;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mwb_decoder u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_soft  (in_soft),
        .done_o   (done_o),
        .data_o   (data_o)
    );

    function automatic bit [15:0] enc(input bit [7:0] d);
        bit [15:0] c;
        for (int i = 0; i < 8; i++) begin
            c[2*i]   = d[i];
            c[2*i+1] = d[i] ^ ((i > 0) ? d[i-1] : 1'b0) ^ ((i > 1) ? d[i-2] : 1'b0);
        end
        return c;
    endfunction

    // expected result from the requirements, by exhaustive search over data words
    function automatic bit [7:0] ref_dec(input logic signed [11:0] v [16]);
        int        mag [16];
        int        ord [16];
        bit [15:0] taken;
        bit [15:0] hard;
        bit [7:0]  bd;
        int        bm;
        taken = '0;
        bd = '0;
        bm = 0;
        for (int p = 0; p < 16; p++) begin
            mag[p]  = (v[p] < 0) ? -int'(v[p]) : int'(v[p]);
            hard[p] = (v[p] < 0);
        end
        for (int r = 0; r < 16; r++) begin
            int b;
            b = -1;
            for (int p = 0; p < 16; p++)
                if (!taken[p] && (b < 0 || mag[p] > mag[b])) b = p;
            ord[r] = b;
            taken[b] = 1'b1;
        end
        for (int c = 0; c < 4; c++) begin
            bit [15:0] s;
            int        kept;
            bit [7:0]  d;
            int        m;
            s = '0;
            kept = 0;
            d = '0;
            for (int r = 0; r < 16; r++) begin
                bit ind;
                if (c > 0 && r == c - 1) continue;
                if (kept == 8) break;
                ind = 1'b0;
                for (int w = 0; w < 256; w++) begin
                    bit [15:0] cw;
                    cw = enc(8'(w));
                    if ((cw & s) == 16'h0 && cw[ord[r]]) ind = 1'b1;
                end
                if (ind) begin
                    s[ord[r]] = 1'b1;
                    kept++;
                end
            end
            for (int w = 255; w >= 0; w--)
                if ((enc(8'(w)) & s) == (hard & s)) d = 8'(w);
            m = 0;
            for (int p = 0; p < 16; p++)
                m += enc(d)[p] ? -int'(v[p]) : int'(v[p]);
            if (c == 0 || m > bm) begin
                bm = m;
                bd = d;
            end
        end
        return bd;
    endfunction

    function automatic int rnd();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return int'(lf);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // driver: pushes the expected word and due edge, then feeds the block
    task automatic send(input logic signed [11:0] v [16], input int gap, input string tag);
        exp_q.push_back(ref_dec(v));
        tag_q.push_back(tag);
        for (int i = 0; i < 16; i++) begin
            if (gap > 0 && (i % gap) == 1) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_soft  = v[i];
            if (i == 15) due_q.push_back(cyc + 1 + LAT);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R1 ready low while decoding", int'(in_ready), 0);
    endtask

    task automatic make_word(input bit [7:0] d, input int amp, input bit noisy,
                             output logic signed [11:0] v [16]);
        bit [15:0] c;
        c = enc(d);
        for (int p = 0; p < 16; p++) begin
            int x;
            x = c[p] ? -amp : amp;
            if (noisy) x += (rnd() % 512);
            v[p] = 12'(x);
        end
    endtask

    // monitor: checks word and due edge at each pulse, then the hold
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    logic [7:0] e;
                    int         due;
                    string      t;
                    logic [7:0] seen;
                    e = exp_q.pop_front();
                    due = due_q.pop_front();
                    t = tag_q.pop_front();
                    check(data_o == e, {t, " decoded word"}, int'(data_o), int'(e));
                    check(cyc == due, "R8 done latency", cyc, due);
                    seen = data_o;
                    @(negedge clk);
                    check(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
                    check(data_o == seen, "R8 data held", int'(data_o), int'(seen));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            over = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic signed [11:0] v [16];
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R9 reset ready", int'(in_ready), 1);
        check(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
        check(data_o == 8'h00, "R9 reset data", int'(data_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        make_word(8'hB4, 400, 1'b0, v);
        send(v, 0, "R2 clean codeword B4");
        make_word(8'h3D, 1000, 1'b0, v);
        send(v, 3, "R2 clean codeword 3D with gaps R1");

        for (int p = 0; p < 16; p++) v[p] = 12'sd0;
        send(v, 0, "R5 all zero input");

        for (int p = 0; p < 16; p++) v[p] = (((16'hA5C3 >> p) & 1) != 0) ? -12'sd100 : 12'sd100;
        send(v, 0, "R3 equal magnitudes");

        for (int p = 0; p < 16; p++) v[p] = ((p % 3) == 0) ? -12'sd2048 : (((p % 3) == 1) ? 12'sd2047 : -12'sd7);
        send(v, 0, "R3 R5 full scale values");

        // garbage offered while busy must be ignored
        while (!in_ready) begin
            in_valid = 1'b1;
            in_soft  = -12'sd1500;
            @(negedge clk);
        end
        in_valid = 1'b0;
        make_word(8'h5A, 300, 1'b1, v);
        send(v, 0, "R1 after busy garbage");

        for (int b = 0; b < 16; b++) begin
            make_word(8'(rnd()), 250, 1'b1, v);
            send(v, (b % 4), "R4 R6 R7 noisy block");
        end

        make_word(8'hC7, 60, 1'b1, v);
        send(v, 0, "R6 R7 low amplitude block");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        if (!over) begin
            over = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule